// File: doc/BRIEF.md
# Tiled Surface Address Translator

This block turns a byte coordinate on a two-dimensional surface into the byte offset where that byte is stored in memory. The coordinate is given as a column `x` in bytes and a row `y`. The surface has a row pitch in bytes. Three storage layouts are supported: plain linear rows, wide-and-short tiles, and narrow-and-tall tiles. The tall-tile layout can also apply an optional address swizzle. Every tile holds 4096 bytes. Tiles follow one another across the surface in row-major order, so a full row of tiles is stored before the next row of tiles starts.

One coordinate can be accepted on every clock cycle. The result appears exactly one cycle later, registered, together with a valid strobe. A flag marks a pitch that the selected tiled layout cannot use, and in that case the address is forced to zero. The output stage is a two-state machine:
- `ST_EMPTY` moves to `ST_FULL` when `in_valid` is high.
- `ST_FULL` stays in `ST_FULL` while `in_valid` stays high.
- `ST_FULL` returns to `ST_EMPTY` when `in_valid` is low.
- `ST_EMPTY` stays in `ST_EMPTY` while `in_valid` is low.

In either state, the address and flag registers load only on an accepted coordinate and otherwise hold.

Top module: `tat_xlate`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_addr` and `out_bad_pitch` are all 0.
- R2: `out_valid` in a cycle equals `in_valid` of the previous cycle. While `in_valid` is low, `out_addr` and `out_bad_pitch` keep their previous values.
- R3: `mode` 2'b00 and 2'b11 select linear layout: address = y*pitch + x.
- R4: `mode` 2'b01 selects wide tiles of 512 bytes by 8 rows. The address is (y/8)*pitch*8 + (x/512)*4096 + (y%8)*512 + (x%512).
- R5: `mode` 2'b10 selects tall tiles of 128 bytes by 32 rows. The address is (y/32)*pitch*32 + (x/128)*4096 + ((x%128)/16*32 + y%32)*16 + x%16.
- R6: In `mode` 2'b10 with `swz_en`=1, bit 6 of the in-tile offset is inverted when bit 9 of that offset is 1.
- R7: `swz_en` has no effect in modes 2'b00, 2'b01 and 2'b11.
- R8: `out_bad_pitch` is 1, with `out_addr` = 0, when the pitch is not a multiple of 512 in `mode` 2'b01 or not a multiple of 128 in `mode` 2'b10. Linear modes never raise the flag.
- R9: In `mode` 2'b10 with a legal pitch, `out_addr[3:0]` equals `x[3:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Coordinate present this cycle |
| in_x | input | X_W (16) | Byte column |
| in_y | input | Y_W (16) | Row |
| in_pitch | input | PITCH_W (16) | Surface row pitch in bytes |
| in_mode | input | 2 | Layout select: 00 linear, 01 wide tiles, 10 tall tiles, 11 linear |
| in_swz | input | 1 | Swizzle enable (tall tiles only) |
| out_valid | output | 1 | Result present |
| out_addr | output | ADDR_W (32) | Translated byte offset |
| out_bad_pitch | output | 1 | Pitch illegal for the selected mode |

## Verification
Several rules are checked by assertions on every cycle:
- the one-cycle valid delay and the holding of results while idle;
- a zero address whenever the pitch flag is set;
- the absence of the flag in linear modes;
- the pass-through of the low address nibble in tall-tile mode.

The actual address arithmetic of each layout can only be shown by the bench scenarios, which compare outputs against hand-computed offsets. These cover tile-boundary crossings in both directions, tile rows below the first, and both polarities of the bit-9 swizzle. They also show that the swizzle has no effect outside tall tiles and that mode 11 behaves as linear.

// File: rtl/tat_pkg.sv
package tat_pkg;
    typedef enum logic [1:0] {
        MD_LINEAR = 2'b00,
        MD_XMAJOR = 2'b01,
        MD_YMAJOR = 2'b10,
        MD_LINALT = 2'b11
    } mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

    // Tile geometry, as log2 values
    localparam int TILE_LG  = 12; // 4096-byte tile
    localparam int UNIT_LG  = 4;  // 16-byte unit in tall tiles
    localparam int YT_W_LG  = 7;  // tall tile: 128 bytes wide
    localparam int YT_H_LG  = 5;  // tall tile: 32 rows
    localparam int XT_W_LG  = 9;  // wide tile: 512 bytes wide
    localparam int XT_H_LG  = 3;  // wide tile: 8 rows
    localparam int SWZ_SRC  = 9;
    localparam int SWZ_DST  = 6;
endpackage

// File: rtl/tat_linmap.sv
module tat_linmap #(
    parameter int X_W     = 16,
    parameter int Y_W     = 16,
    parameter int PITCH_W = 16,
    parameter int ADDR_W  = 32
) (
    input  logic [X_W-1:0]     x,
    input  logic [Y_W-1:0]     y,
    input  logic [PITCH_W-1:0] pitch,
    output logic [ADDR_W-1:0]  addr
);
    always_comb begin
        addr = ADDR_W'(y) * ADDR_W'(pitch) + ADDR_W'(x);
    end
endmodule

// File: rtl/tat_xmap.sv
module tat_xmap
    import tat_pkg::*;
#(
    parameter int X_W     = 16,
    parameter int Y_W     = 16,
    parameter int PITCH_W = 16,
    parameter int ADDR_W  = 32
) (
    input  logic [X_W-1:0]     x,
    input  logic [Y_W-1:0]     y,
    input  logic [PITCH_W-1:0] pitch,
    output logic [ADDR_W-1:0]  addr,
    output logic               pitch_ok
);
    logic [ADDR_W-1:0]  row_base;
    logic [ADDR_W-1:0]  col_base;
    logic [TILE_LG-1:0] in_tile;

    always_comb begin
        // one tile row spans pitch * rows-per-tile bytes
        row_base = (ADDR_W'(y >> XT_H_LG) * ADDR_W'(pitch)) << XT_H_LG;
        col_base = ADDR_W'(x >> XT_W_LG) << TILE_LG;
        in_tile  = {y[XT_H_LG-1:0], x[XT_W_LG-1:0]};
        addr     = row_base + col_base + ADDR_W'(in_tile);
        pitch_ok = (pitch[XT_W_LG-1:0] == '0);
    end
endmodule

// File: rtl/tat_ymap.sv
module tat_ymap
    import tat_pkg::*;
#(
    parameter int X_W     = 16,
    parameter int Y_W     = 16,
    parameter int PITCH_W = 16,
    parameter int ADDR_W  = 32
) (
    input  logic [X_W-1:0]     x,
    input  logic [Y_W-1:0]     y,
    input  logic [PITCH_W-1:0] pitch,
    input  logic               swz,
    output logic [ADDR_W-1:0]  addr,
    output logic               pitch_ok
);
    logic [ADDR_W-1:0]  row_base;
    logic [ADDR_W-1:0]  col_base;
    logic [TILE_LG-1:0] raw_off;
    logic [TILE_LG-1:0] fin_off;

    always_comb begin
        row_base = (ADDR_W'(y >> YT_H_LG) * ADDR_W'(pitch)) << YT_H_LG;
        col_base = ADDR_W'(x >> YT_W_LG) << TILE_LG;
        // units stored column-first: {unit column, row, byte in unit}
        raw_off  = {x[YT_W_LG-1:UNIT_LG], y[YT_H_LG-1:0], x[UNIT_LG-1:0]};
        fin_off  = raw_off;
        fin_off[SWZ_DST] = raw_off[SWZ_DST] ^ (swz & raw_off[SWZ_SRC]);
        addr     = row_base + col_base + ADDR_W'(fin_off);
        pitch_ok = (pitch[YT_W_LG-1:0] == '0);
    end
endmodule

// File: rtl/tat_xlate.sv
module tat_xlate
    import tat_pkg::*;
#(
    parameter int X_W     = 16,
    parameter int Y_W     = 16,
    parameter int PITCH_W = 16,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [X_W-1:0]     in_x,
    input  logic [Y_W-1:0]     in_y,
    input  logic [PITCH_W-1:0] in_pitch,
    input  logic [1:0]         in_mode,
    input  logic               in_swz,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_bad_pitch
);
    logic [ADDR_W-1:0] lin_addr, xt_addr, yt_addr;
    logic              xt_ok, yt_ok;
    logic [ADDR_W-1:0] nxt_addr;
    logic              nxt_bad;
    mode_e             mode;
    stage_e            stage, stage_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic              bad_q;

    assign mode = mode_e'(in_mode);

    tat_linmap #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_lin (
        .x(in_x), .y(in_y), .pitch(in_pitch), .addr(lin_addr)
    );

    tat_xmap #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_xmap (
        .x(in_x), .y(in_y), .pitch(in_pitch), .addr(xt_addr), .pitch_ok(xt_ok)
    );

    tat_ymap #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_ymap (
        .x(in_x), .y(in_y), .pitch(in_pitch), .swz(in_swz),
        .addr(yt_addr), .pitch_ok(yt_ok)
    );

    // layout selection and pitch check
    always_comb begin
        unique case (mode)
            MD_XMAJOR: begin
                nxt_bad  = !xt_ok;
                nxt_addr = xt_ok ? xt_addr : '0;
            end
            MD_YMAJOR: begin
                nxt_bad  = !yt_ok;
                nxt_addr = yt_ok ? yt_addr : '0;
            end
            MD_LINEAR, MD_LINALT: begin
                nxt_bad  = 1'b0;
                nxt_addr = lin_addr;
            end
        endcase
    end

    // output stage transitions
    always_comb begin
        unique case (stage)
            ST_EMPTY: stage_nxt = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  stage_nxt = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= ST_EMPTY;
        else        stage <= stage_nxt;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            bad_q  <= 1'b0;
        end else if (in_valid) begin
            addr_q <= nxt_addr;
            bad_q  <= nxt_bad;
        end
    end

    assign out_valid     = (stage == ST_FULL);
    assign out_addr      = addr_q;
    assign out_bad_pitch = bad_q;

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_addr) && $stable(out_bad_pitch))); // R2
    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad_pitch |-> (out_addr == '0)); // R8
    AST_LIN_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mode == 2'b00 || in_mode == 2'b11)) |=> !out_bad_pitch); // R8
    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b10 && in_pitch[6:0] == 7'd0)
        |=> (out_addr[3:0] == $past(in_x[3:0]))); // R9
endmodule

// File: tb/tat_xlate_test.sv
`timescale 1ns/1ps
module tat_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_x = '0;
    logic [15:0] in_y = '0;
    logic [15:0] in_pitch = '0;
    logic [1:0]  in_mode = '0;
    logic        in_swz = 1'b0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_bad_pitch;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    tat_xlate uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_pitch(in_pitch), .in_mode(in_mode), .in_swz(in_swz),
        .out_valid(out_valid), .out_addr(out_addr), .out_bad_pitch(out_bad_pitch)
    );

    // {mode, swz, pitch, x, y, expected addr, expected flag}
    localparam int NV = 17;
    localparam logic [83:0] VECS [NV] = '{
        {2'd0, 1'b0, 16'd1000, 16'd5,   16'd3,  32'd3005,  1'b0}, // R3
        {2'd3, 1'b0, 16'd700,  16'd10,  16'd2,  32'd1410,  1'b0}, // R3 R8
        {2'd0, 1'b1, 16'd1000, 16'd5,   16'd3,  32'd3005,  1'b0}, // R7
        {2'd1, 1'b0, 16'd1024, 16'd0,   16'd0,  32'd0,     1'b0}, // R4
        {2'd1, 1'b0, 16'd1024, 16'd600, 16'd3,  32'd5720,  1'b0}, // R4
        {2'd1, 1'b0, 16'd1024, 16'd100, 16'd9,  32'd8804,  1'b0}, // R4
        {2'd1, 1'b1, 16'd1024, 16'd100, 16'd9,  32'd8804,  1'b0}, // R7
        {2'd2, 1'b0, 16'd256,  16'd37,  16'd5,  32'd1109,  1'b0}, // R5 R9
        {2'd2, 1'b0, 16'd256,  16'd130, 16'd40, 32'd12418, 1'b0}, // R5
        {2'd2, 1'b1, 16'd256,  16'd37,  16'd5,  32'd1109,  1'b0}, // R6 bit9 clear
        {2'd2, 1'b0, 16'd256,  16'd20,  16'd0,  32'd516,   1'b0}, // R6 reference
        {2'd2, 1'b1, 16'd256,  16'd20,  16'd0,  32'd580,   1'b0}, // R6 bit6 set
        {2'd2, 1'b0, 16'd256,  16'd16,  16'd4,  32'd576,   1'b0}, // R6 reference
        {2'd2, 1'b1, 16'd256,  16'd16,  16'd4,  32'd512,   1'b0}, // R6 bit6 cleared
        {2'd1, 1'b0, 16'd768,  16'd40,  16'd2,  32'd0,     1'b1}, // R8
        {2'd2, 1'b0, 16'd200,  16'd40,  16'd2,  32'd0,     1'b1}, // R8
        {2'd2, 1'b0, 16'd384,  16'd0,   16'd32, 32'd12288, 1'b0}  // R5
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] m, input logic s, input logic b);
        if (b) return "R8";
        if (m == 2'd2) return s ? "R6" : "R5";
        if (s) return "R7";
        if (m == 2'd1) return "R4";
        return "R3";
    endfunction

    task automatic drive(input logic [1:0] m, input logic s, input logic [15:0] p,
                         input logic [15:0] x, input logic [15:0] y);
        in_valid = 1'b1; in_mode = m; in_swz = s; in_pitch = p; in_x = x; in_y = y;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        // R1: reset state, even with a valid coordinate presented
        drive(2'd0, 1'b0, 16'd1000, 16'd5, 16'd3);
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 addr", out_addr, 32'd0);
        chk("R1 flag", {31'd0, out_bad_pitch}, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: each vector presented, checked one edge later
        for (int i = 0; i < NV; i++) begin
            logic [83:0] v;
            v = VECS[i];
            drive(v[83:82], v[81], v[80:65], v[64:49], v[48:33]);
            @(negedge clk);
            chk(req_of(v[83:82], v[81], v[0]), out_addr, v[32:1]);
            chk(req_of(v[83:82], v[81], v[0]), {31'd0, out_bad_pitch}, {31'd0, v[0]});
            chk("R2 valid", {31'd0, out_valid}, 32'd1);
        end

        // R9: low nibble passes through in tall tiles
        drive(2'd2, 1'b1, 16'd512, 16'd1007, 16'd77);
        @(negedge clk);
        chk("R9", {28'd0, out_addr[3:0]}, 32'd15);

        // R2: idle cycle holds results and drops valid
        held = out_addr;
        in_valid = 1'b0; in_x = 16'd999; in_mode = 2'd0; in_pitch = 16'd300;
        @(negedge clk);
        chk("R2 idle valid", {31'd0, out_valid}, 32'd0);
        chk("R2 idle hold", out_addr, held);
        @(negedge clk);
        chk("R2 idle hold2", out_addr, held);

        // R2: back-to-back stream, one cycle latency each
        drive(2'd1, 1'b0, 16'd1024, 16'd511, 16'd7);   // 7*512+511 = 4095
        @(negedge clk);
        chk("R2 stream0", out_addr, 32'd4095);
        drive(2'd1, 1'b0, 16'd1024, 16'd512, 16'd0);   // next tile = 4096
        @(negedge clk);
        chk("R2 stream1", out_addr, 32'd4096);
        drive(2'd2, 1'b0, 16'd384, 16'd127, 16'd31);   // (7*32+31)*16+15 = 4095
        @(negedge clk);
        chk("R5 tile end", out_addr, 32'd4095);
        drive(2'd1, 1'b0, 16'd384, 16'd0, 16'd0);      // 384 illegal for wide tiles
        @(negedge clk);
        chk("R8 x384", {31'd0, out_bad_pitch}, 32'd1);
        chk("R8 x384 addr", out_addr, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 end", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule